// File: doc/BRIEF.md
# Sequential Trigger Engine

The engine examines one vector of channel levels for each accepted sample and walks through a short chain of programmable stages. Each stage holds its own level pattern, in which every channel is either compared against a value or ignored. The pattern can also require a rising or falling edge on one chosen channel, and it can demand that the level pattern has persisted for a given number of samples. Beyond the pattern, a stage can count occurrences of its match, can run a timer with window or timeout behaviour, and can name an abort pattern that sends the sequence back to the start. A stage that completes either moves to its programmed successor or, when it is marked final, fires the trigger.

A trigger produces a single-cycle pulse on `trig_o` and returns the engine to stage 0. A programmable holdoff then freezes the engine for a number of clock cycles. A separate trigger input can fire the engine directly whenever no holdoff is running. The configuration is supplied as static per-stage vectors. The current stage is visible on an output for the capture logic.

Top module: `seq_trig_engine`

## Requirements
- R1: A level pattern matches when `((smp_data ^ val) & mask) == 0`. A mask bit of 1 compares that channel and a mask bit of 0 makes it don't-care. A stage in plain mode (mode code 0) whose pattern matches completes on that sample.
- R2: When the edge enable of a stage is set, a match also requires an edge on channel `edge_ch`. The edge is rising (0 to 1) when `edge_rise` is 1 and falling otherwise. It is measured against the previous accepted sample, and that reference reads all-zero after reset.
- R3: The duration field requires the level pattern to have matched on that many consecutive accepted samples since the stage was entered. A value of 0 or 1 means the first matching sample is enough.
- R4: The occurrence field makes the stage complete only on the Nth matching sample, and the matches need not be consecutive. A value of 0 or 1 means the first match.
- R5: A completed non-final stage moves to its programmed next stage. A non-matching sample leaves the stage unchanged. A cycle with `smp_valid` low changes nothing.
- R6: A nonzero abort mask whose pattern matches returns the engine to stage 0. When the abort pattern and the completion condition hold on the same sample, completion wins.
- R7: Window mode (code 1) completes if a match arrives among the first `limit` samples after entry. If sample `limit` goes by without a match, the engine restarts at stage 0.
- R8: Timeout mode (code 2) completes when `limit` samples pass with no match. A match before that point restarts the engine at stage 0.
- R9: Completion of a stage whose final flag is set produces a one-cycle pulse on `trig_o` in the cycle after the sample, and the engine returns to stage 0.
- R10: After a trigger, the next `cfg_holdoff` clock cycles neither trigger nor advance. During that time samples and `ext_trig` have no effect, and the engine stays at stage 0.
- R11: `ext_trig` high outside holdoff triggers on the next cycle and resets the engine to stage 0. It takes priority over sample evaluation.
- R12: The duration, occurrence and timer counts restart from zero every time a stage is entered, including re-entry into the same stage.
- R13: After reset, `trig_o` is 0 and `stage_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| smp_valid | input | 1 | Marks a cycle that carries a sample |
| smp_data | input | CH_W | Channel levels of the sample |
| ext_trig | input | 1 | Direct trigger request |
| cfg_lvl_mask | input | N_STAGES*CH_W | Per-stage compare mask |
| cfg_lvl_val | input | N_STAGES*CH_W | Per-stage compare value |
| cfg_edge_en | input | N_STAGES | Per-stage edge term enable |
| cfg_edge_rise | input | N_STAGES | 1 selects a rising edge, 0 a falling edge |
| cfg_edge_ch | input | N_STAGES*CHI_W | Per-stage edge channel index |
| cfg_dur | input | N_STAGES*CNT_W | Per-stage minimum run length |
| cfg_occ | input | N_STAGES*CNT_W | Per-stage occurrence count |
| cfg_limit | input | N_STAGES*CNT_W | Per-stage timer limit in samples |
| cfg_mode | input | N_STAGES*2 | 0 plain, 1 window, 2 timeout |
| cfg_abort_mask | input | N_STAGES*CH_W | Per-stage abort mask (0 disables) |
| cfg_abort_val | input | N_STAGES*CH_W | Per-stage abort value |
| cfg_next | input | N_STAGES*STG_W | Successor stage index |
| cfg_final | input | N_STAGES | Completion of this stage fires the trigger |
| cfg_holdoff | input | HOLD_W | Holdoff length in clock cycles |
| trig_o | output | 1 | One-cycle trigger pulse |
| stage_o | output | STG_W | Current stage index |

## Verification
The bench drives stimulus against a reference model and compares the pulse and the stage index after every clock. Values that differ only in don't-care bits separate masking from exact compare. Edge samples preceded by a steady level separate edge detection from level detection. A run broken by one mismatching sample separates consecutive counting from cumulative counting, and scattered matches check the opposite. For the window and timeout stages, the bench places the awaited match just inside the limit, just outside it, or before it, which separates the two timer modes and the boundary of each. Repeated matches that straddle a stage change show whether the counts restart on entry. A steady stream of matches combined with `ext_trig` pins down the length of the holdoff and the priority of the direct trigger.

// File: rtl/trig_seq_pkg.sv
package trig_seq_pkg;
   typedef enum logic [1:0] {
      MODE_PLAIN   = 2'd0,
      MODE_WINDOW  = 2'd1,
      MODE_TIMEOUT = 2'd2,
      MODE_RSVD    = 2'd3
   } stage_mode_e;
endpackage

// File: rtl/trig_pattern_match.sv
module trig_pattern_match #(
   parameter int CH_W  = 8,
   parameter int CHI_W = 3
) (
   input  logic [CH_W-1:0]  smp_i,
   input  logic [CH_W-1:0]  prev_i,
   input  logic [CH_W-1:0]  mask_i,
   input  logic [CH_W-1:0]  val_i,
   input  logic             edge_en_i,
   input  logic             edge_rise_i,
   input  logic [CHI_W-1:0] edge_ch_i,
   output logic             lvl_ok_o,
   output logic             hit_o
);
   logic cur_bit, old_bit, edge_ok;

   assign lvl_ok_o = ((smp_i ^ val_i) & mask_i) == '0;
   assign cur_bit  = smp_i[edge_ch_i];
   assign old_bit  = prev_i[edge_ch_i];
   assign edge_ok  = !edge_en_i ||
                     (edge_rise_i ? (!old_bit && cur_bit) : (old_bit && !cur_bit));
   assign hit_o    = lvl_ok_o && edge_ok;
endmodule

// File: rtl/trig_stage_eval.sv
module trig_stage_eval
   import trig_seq_pkg::*;
#(
   parameter int CNT_W        = 8,
   parameter int USE_DURATION = 1
) (
   input  logic             lvl_ok_i,
   input  logic             hit_i,
   input  logic             abort_i,
   input  logic [CNT_W-1:0] held_q_i,
   input  logic [CNT_W-1:0] occ_q_i,
   input  logic [CNT_W-1:0] tmr_q_i,
   input  logic [CNT_W-1:0] dur_i,
   input  logic [CNT_W-1:0] occ_n_i,
   input  logic [CNT_W-1:0] limit_i,
   input  stage_mode_e      mode_i,
   output logic             take_x_o,
   output logic             take_y_o,
   output logic [CNT_W-1:0] held_d_o,
   output logic [CNT_W-1:0] occ_d_o,
   output logic [CNT_W-1:0] tmr_d_o
);
   localparam logic [CNT_W-1:0] CMAX = '1;

   logic             dur_ok, match, met, expired;
   logic [CNT_W:0]   occ_nx, tmr_nx;

   generate
      if (USE_DURATION != 0) begin : g_dur
         always_comb begin
            if (!lvl_ok_i)              held_d_o = '0;
            else if (held_q_i == CMAX)  held_d_o = CMAX;
            else                        held_d_o = held_q_i + 1'b1;
         end
         assign dur_ok = held_d_o >= dur_i;
      end else begin : g_nodur
         assign held_d_o = '0;
         assign dur_ok   = 1'b1;
      end
   endgenerate

   assign match   = hit_i && dur_ok;
   assign occ_nx  = {1'b0, occ_q_i} + 1'b1;
   assign met     = match && (occ_nx >= {1'b0, occ_n_i});
   assign occ_d_o = (match && occ_q_i != CMAX) ? occ_nx[CNT_W-1:0] : occ_q_i;
   assign tmr_nx  = {1'b0, tmr_q_i} + 1'b1;
   assign expired = tmr_nx >= {1'b0, limit_i};
   assign tmr_d_o = (tmr_q_i == CMAX) ? CMAX : tmr_nx[CNT_W-1:0];

   always_comb begin
      unique case (mode_i)
         MODE_WINDOW: begin
            take_x_o = met;
            take_y_o = abort_i || expired;
         end
         MODE_TIMEOUT: begin
            take_x_o = expired && !met;
            take_y_o = abort_i || met;
         end
         default: begin
            take_x_o = met;
            take_y_o = abort_i;
         end
      endcase
   end
endmodule

// File: rtl/trig_holdoff.sv
module trig_holdoff #(
   parameter int HOLD_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              fire_i,
   input  logic [HOLD_W-1:0] len_i,
   output logic              busy_o
);
   logic [HOLD_W-1:0] cnt_q;

   assign busy_o = cnt_q != '0;

   always_ff @(posedge clk) begin
      if (!rst_n)      cnt_q <= '0;
      else if (fire_i) cnt_q <= len_i;
      else if (busy_o) cnt_q <= cnt_q - 1'b1;
   end

   // R10
   hold_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (fire_i && len_i != '0) |=> busy_o);
endmodule

// File: rtl/seq_trig_engine.sv
module seq_trig_engine
   import trig_seq_pkg::*;
#(
   parameter int CH_W         = 8,
   parameter int N_STAGES     = 4,
   parameter int CNT_W        = 8,
   parameter int HOLD_W       = 8,
   parameter int USE_DURATION = 1,
   localparam int STG_W = (N_STAGES > 1) ? $clog2(N_STAGES) : 1,
   localparam int CHI_W = (CH_W > 1) ? $clog2(CH_W) : 1
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      smp_valid,
   input  logic [CH_W-1:0]           smp_data,
   input  logic                      ext_trig,
   input  logic [N_STAGES*CH_W-1:0]  cfg_lvl_mask,
   input  logic [N_STAGES*CH_W-1:0]  cfg_lvl_val,
   input  logic [N_STAGES-1:0]       cfg_edge_en,
   input  logic [N_STAGES-1:0]       cfg_edge_rise,
   input  logic [N_STAGES*CHI_W-1:0] cfg_edge_ch,
   input  logic [N_STAGES*CNT_W-1:0] cfg_dur,
   input  logic [N_STAGES*CNT_W-1:0] cfg_occ,
   input  logic [N_STAGES*CNT_W-1:0] cfg_limit,
   input  logic [N_STAGES*2-1:0]     cfg_mode,
   input  logic [N_STAGES*CH_W-1:0]  cfg_abort_mask,
   input  logic [N_STAGES*CH_W-1:0]  cfg_abort_val,
   input  logic [N_STAGES*STG_W-1:0] cfg_next,
   input  logic [N_STAGES-1:0]       cfg_final,
   input  logic [HOLD_W-1:0]         cfg_holdoff,
   output logic                      trig_o,
   output logic [STG_W-1:0]          stage_o
);
   generate
      if (N_STAGES != 2 && N_STAGES != 4) begin : g_bad_stages
         $error("N_STAGES must be 2 or 4");
      end
      if (CH_W < 2 || (1 << CHI_W) != CH_W) begin : g_bad_width
         $error("CH_W must be a power of two of at least 2");
      end
      if (CNT_W < 2 || HOLD_W < 1) begin : g_bad_cnt
         $error("counter widths too small");
      end
   endgenerate

   logic [CH_W-1:0]  lmask_a [N_STAGES];
   logic [CH_W-1:0]  lval_a  [N_STAGES];
   logic [CH_W-1:0]  amask_a [N_STAGES];
   logic [CH_W-1:0]  aval_a  [N_STAGES];
   logic [CHI_W-1:0] ech_a   [N_STAGES];
   logic [CNT_W-1:0] dur_a   [N_STAGES];
   logic [CNT_W-1:0] occ_a   [N_STAGES];
   logic [CNT_W-1:0] lim_a   [N_STAGES];
   logic [STG_W-1:0] nxt_a   [N_STAGES];
   stage_mode_e      mode_a  [N_STAGES];

   for (genvar s = 0; s < N_STAGES; s++) begin : g_cfg
      assign lmask_a[s] = cfg_lvl_mask[s*CH_W +: CH_W];
      assign lval_a[s]  = cfg_lvl_val[s*CH_W +: CH_W];
      assign amask_a[s] = cfg_abort_mask[s*CH_W +: CH_W];
      assign aval_a[s]  = cfg_abort_val[s*CH_W +: CH_W];
      assign ech_a[s]   = cfg_edge_ch[s*CHI_W +: CHI_W];
      assign dur_a[s]   = cfg_dur[s*CNT_W +: CNT_W];
      assign occ_a[s]   = cfg_occ[s*CNT_W +: CNT_W];
      assign lim_a[s]   = cfg_limit[s*CNT_W +: CNT_W];
      assign nxt_a[s]   = cfg_next[s*STG_W +: STG_W];
      assign mode_a[s]  = stage_mode_e'(cfg_mode[s*2 +: 2]);
   end

   logic [STG_W-1:0] stage_q;
   logic [CH_W-1:0]  prev_q;
   logic [CNT_W-1:0] held_q, occ_q, tmr_q;
   logic [CNT_W-1:0] held_d, occ_d, tmr_d;
   logic             trig_q, busy, fire;
   logic             lvl_ok, hit, abort_hit, take_x, take_y;
   logic [CH_W-1:0]  sel_amask;

   assign sel_amask = amask_a[stage_q];
   assign abort_hit = (sel_amask != '0) &&
                      (((smp_data ^ aval_a[stage_q]) & sel_amask) == '0);

   trig_pattern_match #(.CH_W(CH_W), .CHI_W(CHI_W)) u_pat (
      .smp_i      (smp_data),
      .prev_i     (prev_q),
      .mask_i     (lmask_a[stage_q]),
      .val_i      (lval_a[stage_q]),
      .edge_en_i  (cfg_edge_en[stage_q]),
      .edge_rise_i(cfg_edge_rise[stage_q]),
      .edge_ch_i  (ech_a[stage_q]),
      .lvl_ok_o   (lvl_ok),
      .hit_o      (hit)
   );

   trig_stage_eval #(.CNT_W(CNT_W), .USE_DURATION(USE_DURATION)) u_eval (
      .lvl_ok_i(lvl_ok),
      .hit_i   (hit),
      .abort_i (abort_hit),
      .held_q_i(held_q),
      .occ_q_i (occ_q),
      .tmr_q_i (tmr_q),
      .dur_i   (dur_a[stage_q]),
      .occ_n_i (occ_a[stage_q]),
      .limit_i (lim_a[stage_q]),
      .mode_i  (mode_a[stage_q]),
      .take_x_o(take_x),
      .take_y_o(take_y),
      .held_d_o(held_d),
      .occ_d_o (occ_d),
      .tmr_d_o (tmr_d)
   );

   assign fire = !busy &&
                 (ext_trig || (smp_valid && take_x && cfg_final[stage_q]));

   trig_holdoff #(.HOLD_W(HOLD_W)) u_hold (
      .clk   (clk),
      .rst_n (rst_n),
      .fire_i(fire),
      .len_i (cfg_holdoff),
      .busy_o(busy)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         stage_q <= '0;
         prev_q  <= '0;
         held_q  <= '0;
         occ_q   <= '0;
         tmr_q   <= '0;
         trig_q  <= 1'b0;
      end else begin
         trig_q <= fire;
         if (smp_valid) prev_q <= smp_data;
         if (!busy) begin
            if (ext_trig || (smp_valid && (take_x || take_y))) begin
               held_q <= '0;
               occ_q  <= '0;
               tmr_q  <= '0;
               if (!ext_trig && take_x && !cfg_final[stage_q])
                  stage_q <= nxt_a[stage_q];
               else
                  stage_q <= '0;
            end else if (smp_valid) begin
               held_q <= held_d;
               occ_q  <= occ_d;
               tmr_q  <= tmr_d;
            end
         end
      end
   end

   assign trig_o  = trig_q;
   assign stage_o = stage_q;

   // R10
   trig_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
      busy |=> !trig_o);
   // R11
   ext_fire_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ext_trig && !busy) |=> trig_o);
   // R9
   trig_home_chk: assert property (@(posedge clk) disable iff (!rst_n)
      trig_o |-> (stage_o == '0));
   // R12
   entry_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (stage_q != $past(stage_q)) |-> (tmr_q == '0 && occ_q == '0 && held_q == '0));
   // R5
   idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!smp_valid && !ext_trig) |=> $stable(stage_q));
endmodule

// File: tb/seq_trig_engine_test.sv
module seq_trig_engine_test;
   localparam int CLK_PERIOD = 10;
   localparam int CH_W = 8, NS = 4, CNT_W = 8, HOLD_W = 8, STG_W = 2, CHI_W = 3;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic smp_valid = 1'b0;
   logic [CH_W-1:0] smp_data = '0;
   logic ext_trig = 1'b0;
   logic [NS*CH_W-1:0]  cfg_lvl_mask, cfg_lvl_val, cfg_abort_mask, cfg_abort_val;
   logic [NS-1:0]       cfg_edge_en, cfg_edge_rise, cfg_final;
   logic [NS*CHI_W-1:0] cfg_edge_ch;
   logic [NS*CNT_W-1:0] cfg_dur, cfg_occ, cfg_limit;
   logic [NS*2-1:0]     cfg_mode;
   logic [NS*STG_W-1:0] cfg_next;
   logic [HOLD_W-1:0]   cfg_holdoff;
   logic trig_o;
   logic [STG_W-1:0] stage_o;

   always #(CLK_PERIOD/2) clk = ~clk;

   seq_trig_engine uut (
      .clk(clk), .rst_n(rst_n), .smp_valid(smp_valid), .smp_data(smp_data),
      .ext_trig(ext_trig), .cfg_lvl_mask(cfg_lvl_mask), .cfg_lvl_val(cfg_lvl_val),
      .cfg_edge_en(cfg_edge_en), .cfg_edge_rise(cfg_edge_rise),
      .cfg_edge_ch(cfg_edge_ch), .cfg_dur(cfg_dur), .cfg_occ(cfg_occ),
      .cfg_limit(cfg_limit), .cfg_mode(cfg_mode), .cfg_abort_mask(cfg_abort_mask),
      .cfg_abort_val(cfg_abort_val), .cfg_next(cfg_next), .cfg_final(cfg_final),
      .cfg_holdoff(cfg_holdoff), .trig_o(trig_o), .stage_o(stage_o)
   );

   int n_cmp = 0;
   int n_bad = 0;
   string cur_req = "R13";

   // reference model state
   int m_lmask[NS], m_lval[NS], m_een[NS], m_erise[NS], m_ech[NS];
   int m_dur[NS], m_occ[NS], m_lim[NS], m_mode[NS], m_amask[NS], m_aval[NS];
   int m_nxt[NS], m_fin[NS];
   int m_hold_len;
   int st, held, occ, tmr, prev, hold;
   int exp_trig, exp_stage;

   function automatic int sat(int x);
      return (x > 255) ? 255 : x;
   endfunction

   task automatic clear_cfg();
      cfg_lvl_mask = '0; cfg_lvl_val = '0; cfg_abort_mask = '0; cfg_abort_val = '0;
      cfg_edge_en = '0; cfg_edge_rise = '0; cfg_final = '0; cfg_edge_ch = '0;
      cfg_dur = '0; cfg_occ = '0; cfg_limit = '0; cfg_mode = '0; cfg_next = '0;
      cfg_holdoff = '0; m_hold_len = 0;
      for (int s = 0; s < NS; s++) begin
         m_lmask[s] = 0; m_lval[s] = 0; m_een[s] = 0; m_erise[s] = 0; m_ech[s] = 0;
         m_dur[s] = 0; m_occ[s] = 0; m_lim[s] = 0; m_mode[s] = 0; m_amask[s] = 0;
         m_aval[s] = 0; m_nxt[s] = 0; m_fin[s] = 0;
      end
   endtask

   task automatic set_stage(int s, int lm, int lv, int nxt, int fin);
      cfg_lvl_mask[s*8 +: 8] = lm[7:0]; m_lmask[s] = lm;
      cfg_lvl_val[s*8 +: 8]  = lv[7:0]; m_lval[s]  = lv;
      cfg_next[s*2 +: 2]     = nxt[1:0]; m_nxt[s]  = nxt;
      cfg_final[s]           = fin[0];   m_fin[s]  = fin;
   endtask

   task automatic set_edge(int s, int ch, int rise);
      cfg_edge_en[s] = 1'b1; m_een[s] = 1;
      cfg_edge_rise[s] = rise[0]; m_erise[s] = rise;
      cfg_edge_ch[s*3 +: 3] = ch[2:0]; m_ech[s] = ch;
   endtask

   task automatic set_count(int s, int dur, int occn, int lim, int mode);
      cfg_dur[s*8 +: 8] = dur[7:0];    m_dur[s] = dur;
      cfg_occ[s*8 +: 8] = occn[7:0];   m_occ[s] = occn;
      cfg_limit[s*8 +: 8] = lim[7:0];  m_lim[s] = lim;
      cfg_mode[s*2 +: 2] = mode[1:0];  m_mode[s] = mode;
   endtask

   task automatic set_abort(int s, int am, int av);
      cfg_abort_mask[s*8 +: 8] = am[7:0]; m_amask[s] = am;
      cfg_abort_val[s*8 +: 8]  = av[7:0]; m_aval[s]  = av;
   endtask

   task automatic model_eval(bit v, int d, bit e);
      bit fire, lvl, eok, hit, match, met, expd, x, y, ab;
      int heldn, pb, b, s;
      fire = 0;
      s = st;
      if (hold > 0) begin
         hold = hold - 1;
      end else if (e) begin
         fire = 1; st = 0; held = 0; occ = 0; tmr = 0;
      end else if (v) begin
         lvl = ((d ^ m_lval[s]) & m_lmask[s]) == 0;
         b = (d >> m_ech[s]) & 1;
         pb = (prev >> m_ech[s]) & 1;
         eok = (m_een[s] == 0) || (m_erise[s] != 0 ? (pb == 0 && b == 1) : (pb == 1 && b == 0));
         hit = lvl && eok;
         heldn = lvl ? sat(held + 1) : 0;
         match = hit && (heldn >= m_dur[s]);
         met = match && (occ + 1 >= m_occ[s]);
         expd = (tmr + 1 >= m_lim[s]);
         ab = (m_amask[s] != 0) && (((d ^ m_aval[s]) & m_amask[s]) == 0);
         if (m_mode[s] == 1) begin x = met; y = ab || expd; end
         else if (m_mode[s] == 2) begin x = expd && !met; y = ab || met; end
         else begin x = met; y = ab; end
         if (x || y) begin
            held = 0; occ = 0; tmr = 0;
            if (x && m_fin[s] != 0) begin fire = 1; st = 0; end
            else if (x) st = m_nxt[s];
            else st = 0;
         end else begin
            held = heldn;
            if (match) occ = sat(occ + 1);
            tmr = sat(tmr + 1);
         end
      end
      if (fire) hold = m_hold_len;
      if (v) prev = d;
      exp_trig = fire;
      exp_stage = st;
   endtask

   task automatic compare();
      n_cmp++;
      if (trig_o !== exp_trig[0] || stage_o !== exp_stage[1:0]) begin
         n_bad++;
         $display("FAIL %s: actual trig=%0b stage=%0d expected trig=%0d stage=%0d",
                  cur_req, trig_o, stage_o, exp_trig, exp_stage);
      end
   endtask

   task automatic step(bit v, int d, bit e);
      smp_valid = v; smp_data = d[7:0]; ext_trig = e;
      model_eval(v, d, e);
      @(negedge clk);
      compare();
   endtask

   task automatic do_reset();
      rst_n = 1'b0; smp_valid = 1'b0; smp_data = '0; ext_trig = 1'b0;
      st = 0; held = 0; occ = 0; tmr = 0; prev = 0; hold = 0;
      exp_trig = 0; exp_stage = 0;
      @(negedge clk); @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      compare();
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      n_bad++;
      $display("FAIL %s: watchdog expired, actual=running expected=finished", cur_req);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

   initial begin
      clear_cfg();
      @(negedge clk);
      // R13 reset state
      cur_req = "R13";
      do_reset();

      // R1 / R9: don't-care bits, trigger one cycle after the sample
      cur_req = "R1/R9";
      clear_cfg();
      set_stage(0, 'hF0, 'hA0, 0, 1);
      do_reset();
      step(1, 'h50, 0); step(1, 'hB0, 0); step(1, 'hA7, 0); step(0, 'hA7, 0);
      step(1, 'hA0, 0); step(0, 0, 0);

      // R5: programmed successors, idle cycles ignored
      cur_req = "R5";
      clear_cfg();
      set_stage(0, 'hFF, 'h01, 2, 0);
      set_stage(2, 'hFF, 'h02, 1, 0);
      set_stage(1, 'hFF, 'h03, 0, 1);
      do_reset();
      step(1, 'h02, 0); step(1, 'h01, 0); step(0, 'h02, 0); step(0, 'h02, 0);
      step(1, 'h03, 0); step(1, 'h02, 0); step(1, 'h03, 0); step(0, 0, 0);

      // R2: rising edge on channel 3 with ch0 high, then falling edge on ch7
      cur_req = "R2";
      clear_cfg();
      set_stage(0, 'h01, 'h01, 0, 1);
      set_edge(0, 3, 1);
      do_reset();
      step(1, 'h01, 0); step(1, 'h08, 0); step(1, 'h00, 0); step(1, 'h09, 0);
      step(1, 'h09, 0); step(0, 0, 0);
      clear_cfg();
      set_stage(0, 'h00, 'h00, 0, 1);
      set_edge(0, 7, 0);
      do_reset();
      step(1, 'h80, 0); step(1, 'h80, 0); step(1, 'h00, 0); step(0, 0, 0);

      // R3: run of three consecutive samples
      cur_req = "R3";
      clear_cfg();
      set_stage(0, 'hFF, 'h55, 0, 1);
      set_count(0, 3, 0, 0, 0);
      do_reset();
      step(1, 'h55, 0); step(1, 'h55, 0); step(1, 'h00, 0);
      step(1, 'h55, 0); step(1, 'h55, 0); step(1, 'h55, 0); step(0, 0, 0);

      // R4: third scattered match
      cur_req = "R4";
      clear_cfg();
      set_stage(0, 'h0F, 'h0A, 0, 1);
      set_count(0, 0, 3, 0, 0);
      do_reset();
      step(1, 'h0A, 0); step(1, 'h1A, 0); step(1, 'h00, 0); step(1, 'h2A, 0);
      step(0, 0, 0);

      // R6: abort restarts; completion wins over abort
      cur_req = "R6";
      clear_cfg();
      set_stage(0, 'hFF, 'h11, 1, 0);
      set_stage(1, 'hFF, 'h22, 0, 1);
      set_abort(1, 'hFF, 'h33);
      do_reset();
      step(1, 'h11, 0); step(1, 'h33, 0); step(1, 'h22, 0); step(1, 'h11, 0);
      step(1, 'h22, 0); step(0, 0, 0);
      set_abort(1, 'h0F, 'h02);
      do_reset();
      step(1, 'h11, 0); step(1, 'h42, 0); step(1, 'h11, 0); step(1, 'h22, 0);
      step(0, 0, 0);

      // R7: window of three samples, inside then outside
      cur_req = "R7";
      clear_cfg();
      set_stage(0, 'hFF, 'hA1, 1, 0);
      set_stage(1, 'hFF, 'hB2, 0, 1);
      set_count(1, 0, 0, 3, 1);
      do_reset();
      step(1, 'hA1, 0); step(1, 0, 0); step(1, 0, 0); step(1, 'hB2, 0); step(0, 0, 0);
      step(1, 'hA1, 0); step(1, 0, 0); step(1, 0, 0); step(1, 0, 0); step(1, 'hB2, 0);
      step(0, 0, 0);

      // R8: timeout of four samples, absent then present
      cur_req = "R8";
      clear_cfg();
      set_stage(0, 'hFF, 'hA1, 1, 0);
      set_stage(1, 'hFF, 'hB2, 0, 1);
      set_count(1, 0, 0, 4, 2);
      do_reset();
      step(1, 'hA1, 0);
      for (int i = 0; i < 5; i++) step(1, 0, 0);
      step(1, 'hA1, 0); step(1, 0, 0); step(1, 'hB2, 0);
      for (int i = 0; i < 5; i++) step(1, 0, 0);

      // R12: occurrence count restarts on stage entry
      cur_req = "R12";
      clear_cfg();
      set_stage(0, 'hFF, 'h77, 1, 0);
      set_stage(1, 'hFF, 'h77, 0, 1);
      set_count(0, 0, 2, 0, 0);
      set_count(1, 0, 2, 0, 0);
      do_reset();
      for (int i = 0; i < 5; i++) step(1, 'h77, 0);
      step(0, 0, 0);

      // R10: holdoff of five cycles blocks samples and ext_trig
      cur_req = "R10";
      clear_cfg();
      set_stage(0, 'hFF, 'h01, 0, 1);
      cfg_holdoff = 8'd5; m_hold_len = 5;
      do_reset();
      for (int i = 0; i < 8; i++) step(1, 'h01, 0);
      step(1, 'h01, 1); step(0, 0, 1); step(0, 0, 0);
      for (int i = 0; i < 7; i++) step(0, 0, i == 5);

      // R11: direct trigger from a later stage, back to back without holdoff
      cur_req = "R11";
      clear_cfg();
      set_stage(0, 'hFF, 'h01, 1, 0);
      set_stage(1, 'hFF, 'h02, 0, 1);
      do_reset();
      step(1, 'h01, 0); step(0, 0, 1); step(1, 'h01, 1); step(1, 'h02, 0);
      step(0, 0, 0);

      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end
endmodule